// File: doc/BRIEF.md
# Streaming Source Freeze Bridge

This block stands between a streaming source that lives in a reconfigurable region and a sink in the static logic. Both sides use a valid/ready interface that carries start-of-packet, end-of-packet, empty, channel, error and data. While the freeze input is low, every field passes straight through and the upstream ready mirrors the downstream ready. While freeze is high, the reconfigurable side is cut off. Upstream ready is held high and every upstream beat is discarded, so the region can be torn down without stalling.

In packet mode the bridge keeps one open-packet flag per channel. When freeze is applied, each channel that still has a packet open is closed with one synthetic beat. That beat has end-of-packet set, the error field set to all ones, and data filled with a fixed marker pattern. Each accepted synthetic beat raises illegal_request for one cycle, so an external status register can record that a packet was cut short. In non-packet mode the bridge only blocks traffic while frozen.

Back-pressure follows a ready-latency rule with latency L (parameter READY_LATENCY). A downstream beat counts as accepted only in a cycle where dn_ready was high L cycles earlier. With L = 0 that is the same cycle. The bridge drives a synthetic valid only in such cycles. Pass-through beats are judged by the same rule when the open-packet flags are updated.

Top module: `fb_stream_freeze_bridge`

## Requirements
- R1: While not blocking (freeze low and no closing pending), dn_valid, sop, eop, empty, channel, error and data equal the upstream inputs in the same cycle, and up_ready equals dn_ready.
- R2: While freeze is high, no upstream beat reaches the downstream side, and up_ready is 1.
- R3: In packet mode, an accepted pass-through beat with sop=1 and eop=0 opens the flag of its channel, and an accepted beat with eop=1 closes it. A packet that ended before freeze produces no synthetic beat.
- R4: A synthetic closing beat has valid=1, eop=1, sop=0, empty=0, error all ones and data equal to 32'hDEADBEEF repeated to DATA_W bits. Its channel is that of the open packet.
- R5: Open channels are closed one per accepted beat, in ascending channel number. A channel's flag clears when its closing beat is accepted.
- R6: illegal_request is 1 in exactly the cycle that follows each accepted synthetic beat, and 0 otherwise.
- R7: A beat is accepted only when dn_ready was high READY_LATENCY cycles earlier. A synthetic valid is driven only in such cycles.
- R8: After freeze falls, pass-through stays blocked (up_ready=1, upstream discarded) until every pending closing beat has been accepted.
- R9: With PACKET_MODE=0, dn_valid is 0 for the whole freeze period, and no synthetic beat or illegal_request is produced.
- R10: A synchronous active-high reset clears all open-packet flags, illegal_request and the ready history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Isolate the reconfigurable side |
| up_valid | input | 1 | Upstream beat valid |
| up_ready | output | 1 | Upstream ready (held 1 while blocking) |
| up_sop | input | 1 | Upstream start of packet |
| up_eop | input | 1 | Upstream end of packet |
| up_empty | input | EMPTY_W | Upstream empty symbol count |
| up_channel | input | CH_W | Upstream channel number |
| up_error | input | ERR_W | Upstream error field |
| up_data | input | DATA_W | Upstream data |
| dn_valid | output | 1 | Downstream beat valid |
| dn_ready | input | 1 | Downstream ready |
| dn_sop | output | 1 | Downstream start of packet |
| dn_eop | output | 1 | Downstream end of packet |
| dn_empty | output | EMPTY_W | Downstream empty count |
| dn_channel | output | CH_W | Downstream channel |
| dn_error | output | ERR_W | Downstream error field |
| dn_data | output | DATA_W | Downstream data |
| illegal_request | output | 1 | One-cycle pulse after each synthetic closing beat |

## Verification
The hardest case to reach is a freeze that is released while closing beats are still pending. It needs two or more channels left open and a sink that refuses beats just as freeze rises. The stimulus opens packets on non-adjacent channels and drops ready one cycle before freeze, so the latency window is empty. It then releases freeze while ready is still low and offers a fresh start-of-packet, which must be discarded. When ready returns, the closing beats drain in channel order. A later freeze then shows that the discarded beat left no flag behind.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // Marker word placed on the data field of synthetic closing beats.
  localparam logic [31:0] CLOSE_WORD = 32'hDEADBEEF;

  // Number of 32-bit copies of the marker needed to cover a data width.
  function automatic int fill_reps(input int width);
    return (width + 31) / 32;
  endfunction
endpackage

// File: rtl/fb_ready_delay.sv
module fb_ready_delay #(
  parameter int LAT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy,
  output logic rdy_dly
);
  generate
    if (LAT == 0) begin : g_direct
      assign rdy_dly = rdy;
    end else begin : g_shift
      logic [LAT-1:0] hist_q;
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= (hist_q << 1) | LAT'(rdy);
      end
      assign rdy_dly = hist_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/fb_open_tracker.sv
module fb_open_tracker #(
  parameter int CH_W   = 2,
  parameter bit ENABLE = 1'b1,
  localparam int NCH   = 1 << CH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pt_fire,
  input  logic            pt_sop,
  input  logic            pt_eop,
  input  logic [CH_W-1:0] pt_ch,
  input  logic            cl_fire,
  input  logic [CH_W-1:0] cl_ch,
  output logic [NCH-1:0]  open_flags
);
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (ENABLE) begin : g_on
        logic flag_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            flag_q <= 1'b0;
          end else if (cl_fire && cl_ch == CH_W'(i)) begin
            flag_q <= 1'b0;
          end else if (pt_fire && pt_ch == CH_W'(i)) begin
            if (pt_eop)      flag_q <= 1'b0;
            else if (pt_sop) flag_q <= 1'b1;
          end
        end
        assign open_flags[i] = flag_q;
      end else begin : g_off
        assign open_flags[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/fb_close_picker.sv
module fb_close_picker #(
  parameter int CH_W = 2,
  localparam int NCH = 1 << CH_W
) (
  input  logic [NCH-1:0]  flags,
  output logic            any,
  output logic [CH_W-1:0] pick_ch,
  output logic [NCH-1:0]  pick_oh
);
  always_comb begin
    pick_ch = '0;
    pick_oh = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (flags[i]) begin
        pick_ch = CH_W'(i);
        pick_oh = NCH'(1) << i;
      end
    end
  end
  assign any = |flags;
endmodule

// File: rtl/fb_stream_freeze_bridge.sv
module fb_stream_freeze_bridge #(
  parameter int DATA_W        = 32,
  parameter int CH_W          = 2,
  parameter int EMPTY_W       = 2,
  parameter int ERR_W         = 1,
  parameter int READY_LATENCY = 0,
  parameter bit PACKET_MODE   = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freeze,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic               up_sop,
  input  logic               up_eop,
  input  logic [EMPTY_W-1:0] up_empty,
  input  logic [CH_W-1:0]    up_channel,
  input  logic [ERR_W-1:0]   up_error,
  input  logic [DATA_W-1:0]  up_data,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic               dn_sop,
  output logic               dn_eop,
  output logic [EMPTY_W-1:0] dn_empty,
  output logic [CH_W-1:0]    dn_channel,
  output logic [ERR_W-1:0]   dn_error,
  output logic [DATA_W-1:0]  dn_data,
  output logic               illegal_request
);
  localparam int NCH  = 1 << CH_W;
  localparam int REPS = fb_pkg::fill_reps(DATA_W);
  localparam logic [REPS*32-1:0] FILL_WIDE = {REPS{fb_pkg::CLOSE_WORD}};
  localparam logic [DATA_W-1:0]  CLOSE_FILL = FILL_WIDE[DATA_W-1:0];

  logic            rdly;
  logic [NCH-1:0]  open_flags;
  logic            any_open;
  logic [CH_W-1:0] close_ch;
  logic [NCH-1:0]  close_oh;
  logic            drain_q;
  logic            closing;
  logic            gate;
  logic            syn_fire;
  logic            pt_fire;
  logic            illegal_q;

  fb_ready_delay #(.LAT(READY_LATENCY)) u_rdly (
    .clk(clk), .rst(rst), .rdy(dn_ready), .rdy_dly(rdly)
  );

  fb_open_tracker #(.CH_W(CH_W), .ENABLE(PACKET_MODE)) u_track (
    .clk(clk), .rst(rst),
    .pt_fire(pt_fire), .pt_sop(up_sop), .pt_eop(up_eop), .pt_ch(up_channel),
    .cl_fire(syn_fire), .cl_ch(close_ch),
    .open_flags(open_flags)
  );

  fb_close_picker #(.CH_W(CH_W)) u_pick (
    .flags(open_flags), .any(any_open), .pick_ch(close_ch), .pick_oh(close_oh)
  );

  // Closing stays active after freeze falls until no packet is open.
  assign closing  = PACKET_MODE && (freeze || drain_q) && any_open;
  assign gate     = freeze || closing;
  assign syn_fire = closing && rdly;
  assign pt_fire  = !gate && up_valid && rdly;

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      drain_q   <= freeze || closing;
      illegal_q <= syn_fire;
    end
  end

  always_comb begin
    if (gate) begin
      up_ready   = 1'b1;
      dn_valid   = syn_fire;
      dn_sop     = 1'b0;
      dn_eop     = syn_fire;
      dn_empty   = '0;
      dn_channel = close_ch;
      dn_error   = syn_fire ? '1 : '0;
      dn_data    = syn_fire ? CLOSE_FILL : '0;
    end else begin
      up_ready   = dn_ready;
      dn_valid   = up_valid;
      dn_sop     = up_sop;
      dn_eop     = up_eop;
      dn_empty   = up_empty;
      dn_channel = up_channel;
      dn_error   = up_error;
      dn_data    = up_data;
    end
  end

  assign illegal_request = illegal_q;
endmodule

// File: rtl/fb_bridge_checker.sv
module fb_bridge_checker #(
  parameter int DATA_W      = 32,
  parameter int CH_W        = 2,
  parameter int ERR_W       = 1,
  parameter bit PACKET_MODE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              freeze,
  input logic              up_ready,
  input logic              dn_valid,
  input logic              dn_sop,
  input logic              dn_eop,
  input logic [ERR_W-1:0]  dn_error,
  input logic [DATA_W-1:0] dn_data,
  input logic              illegal_request,
  input logic              syn_fire,
  input logic              rdly,
  input logic [(1<<CH_W)-1:0] close_oh
);
  localparam int REPS = fb_pkg::fill_reps(DATA_W);
  localparam logic [REPS*32-1:0] FILL_WIDE = {REPS{fb_pkg::CLOSE_WORD}};
  localparam logic [DATA_W-1:0]  FILL = FILL_WIDE[DATA_W-1:0];

  assert_frozen_ready_R2: assert property (@(posedge clk) disable iff (rst)
    freeze |-> up_ready);

  assert_frozen_only_closing_R2: assert property (@(posedge clk) disable iff (rst)
    (freeze && dn_valid) |-> (dn_eop && (&dn_error)));

  assert_close_shape_R4: assert property (@(posedge clk) disable iff (rst)
    syn_fire |-> (dn_valid && dn_eop && !dn_sop && dn_data == FILL));

  assert_single_pick_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(close_oh));

  assert_illegal_after_close_R6: assert property (@(posedge clk) disable iff (rst)
    syn_fire |=> illegal_request);

  assert_illegal_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    illegal_request |-> $past(syn_fire));

  assert_close_in_window_R7: assert property (@(posedge clk) disable iff (rst)
    syn_fire |-> rdly);

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !illegal_request);

  generate
    if (!PACKET_MODE) begin : g_np
      assert_np_idle_R9: assert property (@(posedge clk) disable iff (rst)
        freeze |-> (!dn_valid && !illegal_request));
    end
  endgenerate
endmodule

bind fb_stream_freeze_bridge fb_bridge_checker #(
  .DATA_W(DATA_W), .CH_W(CH_W), .ERR_W(ERR_W), .PACKET_MODE(PACKET_MODE)
) u_chk (
  .clk(clk), .rst(rst), .freeze(freeze), .up_ready(up_ready),
  .dn_valid(dn_valid), .dn_sop(dn_sop), .dn_eop(dn_eop), .dn_error(dn_error),
  .dn_data(dn_data), .illegal_request(illegal_request),
  .syn_fire(syn_fire), .rdly(rdly), .close_oh(close_oh)
);

// File: tb/fb_stream_freeze_bridge_tb.sv
`timescale 1ns/1ps
module fb_stream_freeze_bridge_tb;
  localparam int DW = 32, CW = 2, EW = 2, RW = 1, LAT = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic freeze = 1'b0;
  logic up_valid = 1'b0, up_sop = 1'b0, up_eop = 1'b0, dn_ready = 1'b0;
  logic [EW-1:0] up_empty = '0;
  logic [CW-1:0] up_channel = '0;
  logic [RW-1:0] up_error = '0;
  logic [DW-1:0] up_data = '0;

  logic up_ready, dn_valid, dn_sop, dn_eop, illegal_request;
  logic [EW-1:0] dn_empty;
  logic [CW-1:0] dn_channel;
  logic [RW-1:0] dn_error;
  logic [DW-1:0] dn_data;

  logic np_up_ready, np_dn_valid, np_dn_sop, np_dn_eop, np_illegal;
  logic [EW-1:0] np_dn_empty;
  logic [CW-1:0] np_dn_channel;
  logic [RW-1:0] np_dn_error;
  logic [DW-1:0] np_dn_data;

  always #2.5 clk = ~clk;

  fb_stream_freeze_bridge #(.DATA_W(DW), .CH_W(CW), .EMPTY_W(EW), .ERR_W(RW),
    .READY_LATENCY(LAT), .PACKET_MODE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .freeze(freeze),
    .up_valid(up_valid), .up_ready(up_ready), .up_sop(up_sop), .up_eop(up_eop),
    .up_empty(up_empty), .up_channel(up_channel), .up_error(up_error), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_sop(dn_sop), .dn_eop(dn_eop),
    .dn_empty(dn_empty), .dn_channel(dn_channel), .dn_error(dn_error), .dn_data(dn_data),
    .illegal_request(illegal_request));

  fb_stream_freeze_bridge #(.DATA_W(DW), .CH_W(CW), .EMPTY_W(EW), .ERR_W(RW),
    .READY_LATENCY(0), .PACKET_MODE(1'b0)) u_np (
    .clk(clk), .rst(rst), .freeze(freeze),
    .up_valid(up_valid), .up_ready(np_up_ready), .up_sop(up_sop), .up_eop(up_eop),
    .up_empty(up_empty), .up_channel(up_channel), .up_error(up_error), .up_data(up_data),
    .dn_valid(np_dn_valid), .dn_ready(dn_ready), .dn_sop(np_dn_sop), .dn_eop(np_dn_eop),
    .dn_empty(np_dn_empty), .dn_channel(np_dn_channel), .dn_error(np_dn_error),
    .dn_data(np_dn_data), .illegal_request(np_illegal));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int closes_seen = 0;
  int pulses_seen = 0;
  int obs[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model state
  bit   m_open[4];
  bit   m_drain = 1'b0;
  bit   m_ill = 1'b0;
  bit   hq[$];

  function automatic bit m_rdly();
    if (LAT == 0) return dn_ready;
    return hq[LAT-1];
  endfunction

  function automatic int m_lowest();
    foreach (m_open[i]) if (m_open[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_open[i]) m_open[i] = 1'b0;
      m_drain = 1'b0;
      m_ill = 1'b0;
      hq.delete();
      for (int k = 0; k < LAT; k++) hq.push_back(1'b0);
    end else begin
      int lo;
      bit rd, closing, gate;
      lo = m_lowest();
      rd = m_rdly();
      closing = (freeze || m_drain) && (lo >= 0);
      gate = freeze || closing;
      m_ill = closing && rd;
      if (closing && rd) m_open[lo] = 1'b0;
      else if (!gate && up_valid && rd) begin
        if (up_eop) m_open[up_channel] = 1'b0;
        else if (up_sop) m_open[up_channel] = 1'b1;
      end
      m_drain = gate;
      m_drain = freeze || closing;
      if (LAT > 0) begin
        hq.push_front(dn_ready);
        void'(hq.pop_back());
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      int lo;
      bit rd, closing, gate, exp_v;
      lo = m_lowest();
      rd = m_rdly();
      closing = (freeze || m_drain) && (lo >= 0);
      gate = freeze || closing;
      exp_v = gate ? (closing && rd) : up_valid;
      if (gate) chk(dn_valid == exp_v, "R7 closing valid", dn_valid, exp_v);
      else      chk(dn_valid == exp_v, "R1 valid", dn_valid, exp_v);
      if (gate) chk(up_ready == 1'b1, "R8 up_ready while blocking", up_ready, 1);
      else      chk(up_ready == dn_ready, "R1 up_ready", up_ready, dn_ready);
      if (gate && exp_v) begin
        chk(dn_channel == lo, "R5 closing channel", dn_channel, lo);
        chk(dn_data == 32'hDEADBEEF, "R4 closing data", dn_data, 32'hDEADBEEF);
        chk(dn_eop && !dn_sop && dn_error == 1'b1 && dn_empty == 0,
            "R4 closing flags", {dn_sop, dn_eop, dn_error}, 3'b011);
        obs.push_back(int'(dn_channel));
        closes_seen++;
      end else if (exp_v) begin
        chk({dn_sop, dn_eop, dn_empty, dn_channel, dn_error, dn_data} ==
            {up_sop, up_eop, up_empty, up_channel, up_error, up_data},
            "R1 fields", dn_data, up_data);
      end
      chk(illegal_request == m_ill, "R6 illegal_request", illegal_request, m_ill);
      if (illegal_request) pulses_seen++;
      if (freeze) begin
        chk(np_dn_valid == 1'b0 && np_illegal == 1'b0, "R9 idle when frozen",
            {np_dn_valid, np_illegal}, 0);
        chk(np_up_ready == 1'b1, "R2 np ready while frozen", np_up_ready, 1);
      end else begin
        chk(np_dn_valid == up_valid && np_dn_data == up_data, "R9 pass-through",
            np_dn_valid, up_valid);
      end
    end
  end

  task automatic drive(input bit v, input bit s, input bit e, input int ch,
                       input logic [31:0] d, input bit r, input bit f);
    @(negedge clk);
    up_valid = v; up_sop = s; up_eop = e; up_channel = CW'(ch);
    up_data = d; dn_ready = r; freeze = f;
    up_empty = EW'(ch); up_error = '0;
  endtask

  task automatic expect_obs(input string tag, input int e0, input int e1);
    int n;
    n = (e0 < 0) ? 0 : ((e1 < 0) ? 1 : 2);
    chk(obs.size() == n, tag, obs.size(), n);
    if (n >= 1 && obs.size() >= 1) chk(obs[0] == e0, tag, obs[0], e0);
    if (n >= 2 && obs.size() >= 2) chk(obs[1] == e1, tag, obs[1], e1);
    obs.delete();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) drive(0, 0, 0, 0, 0, 1, 0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(illegal_request == 1'b0 && dn_valid == 1'b0, "R10 reset state",
        {illegal_request, dn_valid}, 0);

    // R1: pass-through with varied patterns and ready toggling
    for (int i = 0; i < 24; i++)
      drive(i % 3 != 0, 1, 1, i % 4, 32'h1000 + i * 32'h0111, (i % 5) != 2, 0);
    drive(0, 0, 0, 0, 0, 1, 0);

    // R3/R5: open ch3 then ch1, freeze, expect closes in order 1,3
    drive(1, 1, 0, 3, 32'hA3, 1, 0);
    drive(1, 1, 0, 1, 32'hA1, 1, 0);
    drive(1, 0, 0, 1, 32'hA2, 1, 0);
    repeat (4) drive(1, 1, 0, 2, 32'h55, 1, 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    expect_obs("R5 ascending close order", 1, 3);

    // R8/R7: open ch2 and ch0, drop ready before freeze, release freeze while pending
    drive(1, 1, 0, 2, 32'hB2, 1, 0);
    drive(1, 1, 0, 0, 32'hB0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(1, 1, 0, 1, 32'hC1, 0, 0);
    #1;
    chk(up_ready == 1'b1 && dn_valid == 1'b0, "R8 blocked after release",
        {up_ready, dn_valid}, 2'b10);
    drive(1, 1, 0, 1, 32'hC1, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    expect_obs("R7 closes after ready window", 0, 2);

    // R8: discarded sop left nothing open; freeze now yields no beats
    repeat (3) drive(0, 0, 0, 0, 0, 1, 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    expect_obs("R8 discarded beat opened nothing", -1, -1);

    // R3: packet finished before freeze gives no close
    drive(1, 1, 0, 2, 32'hD0, 1, 0);
    drive(1, 0, 1, 2, 32'hD1, 1, 0);
    repeat (3) drive(0, 0, 0, 0, 0, 1, 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    expect_obs("R3 finished packet not closed", -1, -1);

    // R10: reset while a packet is open clears the flag
    drive(1, 1, 0, 3, 32'hE0, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 1, 0);
    rst = 1'b0;
    repeat (3) drive(0, 0, 0, 0, 0, 1, 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    expect_obs("R10 reset cleared flags", -1, -1);

    repeat (3) drive(0, 0, 0, 0, 0, 1, 0);
    chk(pulses_seen == closes_seen, "R6 one pulse per close", pulses_seen, closes_seen);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule